// File: doc/BRIEF.md
# Video Gate Array Command Decoder

This block receives single-byte command writes addressed to a video and memory control chip and turns them into held control state. The two most significant bits of each byte choose one of four command classes: choosing a pen, setting the colour of the chosen pen, controlling the screen mode and ROM windows, or passing a RAM layout code to a separate bank mapper. The block keeps the current pen index and a palette of sixteen pens plus one border entry. A palette read port lets the pixel side fetch any entry.

A screen mode write does not take effect at once. The new mode is held as pending, and the video timing logic moves it into the active mode register with a strobe at a point of its choosing, such as a line boundary. The mode/ROM command also drives the enables for the lower and upper ROM windows. Setting one bit in that command sends a one-cycle reset pulse to an external interrupt counter. RAM layout codes go to the bank mapper only when the 128 KB expansion is enabled.

All outputs are registered. A write that the bench presents at a clock edge shows its effect in the cycle after that edge.

Top module: `gate_cmd_decoder`

## Requirements
- R1: When `wr_en` is high, bits 7:6 of `wr_data` select exactly one command: 00 pen select, 01 colour set, 10 mode/ROM control, 11 RAM layout. When `wr_en` is low, no state changes except through `mode_apply`.
- R2: A pen-select write loads `wr_data[4:0]` into `pen_idx`, visible in the next cycle.
- R3: A colour-set write stores `wr_data[4:0]` into the palette entry addressed by the current `pen_idx`. There are entries 0 to 16, and entry 16 is the border. A write while `pen_idx` > 16 changes no entry. `pal_rd_colour` returns the entry at `pal_rd_idx` combinationally, and returns 0 for an index above 16.
- R4: A mode/ROM write loads `wr_data[1:0]` into `mode_pending` and leaves `mode_active` unchanged.
- R5: `mode_apply` high at an edge copies the value `mode_pending` held before that edge into `mode_active`. Without `mode_apply`, `mode_active` holds its value.
- R6: A mode/ROM write sets `lower_rom_en` to the inverse of `wr_data[2]` and `upper_rom_en` to the inverse of `wr_data[3]`. No other command changes either flag.
- R7: `irq_cnt_reset` is high for exactly the cycle after a mode/ROM write with `wr_data[4]` set, and is low otherwise.
- R8: A RAM-layout write with `ram_exp_en` high loads `wr_data[2:0]` into `bank_cfg` and raises `bank_cfg_valid` for one cycle. With `ram_exp_en` low, the write changes neither output.
- R9: During and after reset: `pen_idx` = 0, both modes = 0, both ROM enables = 1, all palette entries = 0, `bank_cfg` = 0, and both pulse outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 8 | Command byte |
| mode_apply | input | 1 | Strobe from video timing to activate the pending mode |
| ram_exp_en | input | 1 | 128 KB expansion present; gates RAM layout forwarding |
| pal_rd_idx | input | 5 | Palette read index |
| pal_rd_colour | output | 5 | Palette entry at `pal_rd_idx` |
| pen_idx | output | 5 | Currently selected pen |
| mode_pending | output | 2 | Posted next screen mode |
| mode_active | output | 2 | Screen mode in effect |
| lower_rom_en | output | 1 | Lower ROM window enabled |
| upper_rom_en | output | 1 | Upper ROM window enabled |
| irq_cnt_reset | output | 1 | One-cycle interrupt counter reset pulse |
| bank_cfg | output | 3 | Last forwarded RAM layout code |
| bank_cfg_valid | output | 1 | One-cycle strobe with each forwarded code |

## Verification
The directed patterns first visit each pen, including the border, through select followed by colour writes. A write with an out-of-range pen index shows whether stray colour writes are dropped or wrap onto a real entry. Mode writes are placed with and without a coincident `mode_apply`, which separates "apply takes the old pending value" from "apply takes the new one". All four ROM-bit combinations are covered, along with RAM layout writes with the expansion on and off. A long run of random bytes, strobes and sweeping read indices then checks every output against a behavioural model on every cycle, including the out-of-range palette reads.

// File: rtl/gate_cmd_pkg.sv
`timescale 1ns/1ps
package gate_cmd_pkg;
    // Command class carried in the two top bits of the written byte
    typedef enum logic [1:0] {
        CMD_PEN    = 2'b00,
        CMD_COLOUR = 2'b01,
        CMD_MODE   = 2'b10,
        CMD_LAYOUT = 2'b11
    } cmd_e;

    localparam int BYTE_W      = 8;
    localparam int CMD_LSB     = 6;
    localparam int LOWER_BIT   = 2;
    localparam int UPPER_BIT   = 3;
    localparam int IRQ_BIT     = 4;
endpackage

// File: rtl/gcd_decode.sv
`timescale 1ns/1ps
module gcd_decode
    import gate_cmd_pkg::*;
#(
    parameter int PEN_W  = 5,
    parameter int COL_W  = 5,
    parameter int MODE_W = 2,
    parameter int BANK_W = 3
) (
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              pen_we,
    output logic              colour_we,
    output logic              mode_we,
    output logic              layout_we,
    output logic [PEN_W-1:0]  pen_field,
    output logic [COL_W-1:0]  colour_field,
    output logic [MODE_W-1:0] mode_field,
    output logic              lower_off,
    output logic              upper_off,
    output logic              irq_req,
    output logic [BANK_W-1:0] bank_field
);
    cmd_e cmd;

    always_comb begin
        cmd          = cmd_e'(wr_data[BYTE_W-1:CMD_LSB]);
        pen_we       = wr_en && (cmd == CMD_PEN);
        colour_we    = wr_en && (cmd == CMD_COLOUR);
        mode_we      = wr_en && (cmd == CMD_MODE);
        layout_we    = wr_en && (cmd == CMD_LAYOUT);
        pen_field    = wr_data[PEN_W-1:0];
        colour_field = wr_data[COL_W-1:0];
        mode_field   = wr_data[MODE_W-1:0];
        lower_off    = wr_data[LOWER_BIT];
        upper_off    = wr_data[UPPER_BIT];
        irq_req      = wr_data[IRQ_BIT];
        bank_field   = wr_data[BANK_W-1:0];
    end
endmodule

// File: rtl/gcd_palette.sv
`timescale 1ns/1ps
module gcd_palette #(
    parameter int NUM_ENTRIES = 17,
    parameter int IDX_W       = 5,
    parameter int COL_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [COL_W-1:0] wr_colour,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [COL_W-1:0] rd_colour
);
    localparam int FLAT_W = NUM_ENTRIES * COL_W;

    logic [FLAT_W-1:0] flat_q;

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        logic [COL_W-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we && (wr_idx == IDX_W'(e))) ent_d = wr_colour;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign flat_q[e*COL_W +: COL_W] = ent_q;
    end

    // Compare-select read; indices without an entry read as zero
    always_comb begin
        rd_colour = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (rd_idx == IDX_W'(e)) rd_colour = flat_q[e*COL_W +: COL_W];
        end
    end
endmodule

// File: rtl/gate_cmd_decoder.sv
`timescale 1ns/1ps
module gate_cmd_decoder
    import gate_cmd_pkg::*;
#(
    parameter int PEN_W    = 5,
    parameter int COL_W    = 5,
    parameter int NUM_PENS = 17,
    parameter int MODE_W   = 2,
    parameter int BANK_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              mode_apply,
    input  logic              ram_exp_en,
    input  logic [PEN_W-1:0]  pal_rd_idx,
    output logic [COL_W-1:0]  pal_rd_colour,
    output logic [PEN_W-1:0]  pen_idx,
    output logic [MODE_W-1:0] mode_pending,
    output logic [MODE_W-1:0] mode_active,
    output logic              lower_rom_en,
    output logic              upper_rom_en,
    output logic              irq_cnt_reset,
    output logic [BANK_W-1:0] bank_cfg,
    output logic              bank_cfg_valid
);
    localparam logic [PEN_W-1:0] LAST_PEN = PEN_W'(NUM_PENS - 1);

    typedef struct packed {
        logic [PEN_W-1:0]  pen;
        logic [MODE_W-1:0] mode_nxt;
        logic [MODE_W-1:0] mode_cur;
        logic              lower_en;
        logic              upper_en;
        logic              irq_pulse;
        logic [BANK_W-1:0] bank;
        logic              bank_strobe;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        pen: '0, mode_nxt: '0, mode_cur: '0, lower_en: 1'b1, upper_en: 1'b1,
        irq_pulse: 1'b0, bank: '0, bank_strobe: 1'b0
    };

    logic              pen_we, colour_we, mode_we, layout_we;
    logic [PEN_W-1:0]  pen_field;
    logic [COL_W-1:0]  colour_field;
    logic [MODE_W-1:0] mode_field;
    logic              lower_off, upper_off, irq_req;
    logic [BANK_W-1:0] bank_field;
    logic              pal_we;
    ctrl_t             ctrl_d, ctrl_q;

    gcd_decode #(
        .PEN_W (PEN_W),
        .COL_W (COL_W),
        .MODE_W(MODE_W),
        .BANK_W(BANK_W)
    ) u_decode (
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .pen_we      (pen_we),
        .colour_we   (colour_we),
        .mode_we     (mode_we),
        .layout_we   (layout_we),
        .pen_field   (pen_field),
        .colour_field(colour_field),
        .mode_field  (mode_field),
        .lower_off   (lower_off),
        .upper_off   (upper_off),
        .irq_req     (irq_req),
        .bank_field  (bank_field)
    );

    // Colour writes to a pen index with no entry are dropped
    assign pal_we = colour_we && (ctrl_q.pen <= LAST_PEN);

    gcd_palette #(
        .NUM_ENTRIES(NUM_PENS),
        .IDX_W      (PEN_W),
        .COL_W      (COL_W)
    ) u_palette (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (pal_we),
        .wr_idx   (ctrl_q.pen),
        .wr_colour(colour_field),
        .rd_idx   (pal_rd_idx),
        .rd_colour(pal_rd_colour)
    );

    always_comb begin
        ctrl_d             = ctrl_q;
        ctrl_d.irq_pulse   = 1'b0;
        ctrl_d.bank_strobe = 1'b0;
        if (pen_we) ctrl_d.pen = pen_field;
        if (mode_we) begin
            ctrl_d.mode_nxt  = mode_field;
            ctrl_d.lower_en  = !lower_off;
            ctrl_d.upper_en  = !upper_off;
            ctrl_d.irq_pulse = irq_req;
        end
        // Activation takes the pending value held before this edge
        if (mode_apply) ctrl_d.mode_cur = ctrl_q.mode_nxt;
        if (layout_we && ram_exp_en) begin
            ctrl_d.bank        = bank_field;
            ctrl_d.bank_strobe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= CTRL_RESET;
        else        ctrl_q <= ctrl_d;
    end

    assign pen_idx        = ctrl_q.pen;
    assign mode_pending   = ctrl_q.mode_nxt;
    assign mode_active    = ctrl_q.mode_cur;
    assign lower_rom_en   = ctrl_q.lower_en;
    assign upper_rom_en   = ctrl_q.upper_en;
    assign irq_cnt_reset  = ctrl_q.irq_pulse;
    assign bank_cfg       = ctrl_q.bank;
    assign bank_cfg_valid = ctrl_q.bank_strobe;
endmodule

// File: rtl/gcd_checker.sv
`timescale 1ns/1ps
module gcd_checker #(
    parameter int PEN_W  = 5,
    parameter int MODE_W = 2,
    parameter int BANK_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic              mode_apply,
    input logic              ram_exp_en,
    input logic [PEN_W-1:0]  pen_idx,
    input logic [MODE_W-1:0] mode_pending,
    input logic [MODE_W-1:0] mode_active,
    input logic              lower_rom_en,
    input logic              upper_rom_en,
    input logic              irq_cnt_reset,
    input logic [BANK_W-1:0] bank_cfg,
    input logic              bank_cfg_valid
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_PEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(wr_en) && ($past(wr_data[7:6]) == 2'b00)
        |-> pen_idx == $past(wr_data[PEN_W-1:0])); // R2

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(mode_apply) |-> $stable(mode_active)); // R5

    AST_MODE_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(mode_apply) |-> mode_active == $past(mode_pending)); // R5

    AST_ROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !($past(wr_en) && ($past(wr_data[7:6]) == 2'b10))
        |-> $stable({lower_rom_en, upper_rom_en})); // R6

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> irq_cnt_reset ==
            ($past(wr_en) && ($past(wr_data[7:6]) == 2'b10) && $past(wr_data[4]))); // R7

    AST_BANK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && bank_cfg_valid
        |-> $past(ram_exp_en) && $past(wr_en) && ($past(wr_data[7:6]) == 2'b11)
            && bank_cfg == $past(wr_data[BANK_W-1:0])); // R8
endmodule

bind gate_cmd_decoder gcd_checker #(
    .PEN_W (PEN_W),
    .MODE_W(MODE_W),
    .BANK_W(BANK_W)
) u_gcd_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .mode_apply    (mode_apply),
    .ram_exp_en    (ram_exp_en),
    .pen_idx       (pen_idx),
    .mode_pending  (mode_pending),
    .mode_active   (mode_active),
    .lower_rom_en  (lower_rom_en),
    .upper_rom_en  (upper_rom_en),
    .irq_cnt_reset (irq_cnt_reset),
    .bank_cfg      (bank_cfg),
    .bank_cfg_valid(bank_cfg_valid)
);

// File: tb/gate_cmd_decoder_bench.sv
`timescale 1ns/1ps
module gate_cmd_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       mode_apply = 1'b0;
    logic       ram_exp_en = 1'b0;
    logic [4:0] pal_rd_idx = 5'd0;
    logic [4:0] pal_rd_colour, pen_idx;
    logic [1:0] mode_pending, mode_active;
    logic       lower_rom_en, upper_rom_en, irq_cnt_reset, bank_cfg_valid;
    logic [2:0] bank_cfg;

    always #2.5 clk = ~clk; // 200 MHz

    gate_cmd_decoder u_gate_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .mode_apply(mode_apply), .ram_exp_en(ram_exp_en),
        .pal_rd_idx(pal_rd_idx), .pal_rd_colour(pal_rd_colour),
        .pen_idx(pen_idx), .mode_pending(mode_pending), .mode_active(mode_active),
        .lower_rom_en(lower_rom_en), .upper_rom_en(upper_rom_en),
        .irq_cnt_reset(irq_cnt_reset), .bank_cfg(bank_cfg),
        .bank_cfg_valid(bank_cfg_valid)
    );

    // Behavioural reference state
    int m_pen, m_pend, m_act, m_low, m_up, m_irq, m_bank, m_bval;
    int m_pal [17];
    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic check(input string req, input string what, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_pen = 0; m_pend = 0; m_act = 0; m_low = 1; m_up = 1;
        m_irq = 0; m_bank = 0; m_bval = 0;
        for (int i = 0; i < 17; i++) m_pal[i] = 0;
    endtask

    task automatic model_step();
        int cmd;
        int old_pend;
        old_pend = m_pend;
        m_irq = 0;
        m_bval = 0;
        cmd = int'(wr_data[7:6]);
        if (wr_en) begin
            if (cmd == 0) m_pen = int'(wr_data[4:0]);
            else if (cmd == 1) begin
                if (m_pen < 17) m_pal[m_pen] = int'(wr_data[4:0]);
            end else if (cmd == 2) begin
                m_pend = int'(wr_data[1:0]);
                m_low = wr_data[2] ? 0 : 1;
                m_up  = wr_data[3] ? 0 : 1;
                m_irq = wr_data[4] ? 1 : 0;
            end else if (ram_exp_en) begin
                m_bank = int'(wr_data[2:0]);
                m_bval = 1;
            end
        end
        if (mode_apply) m_act = old_pend;
    endtask

    task automatic compare_all();
        int exp_col;
        string rq;
        exp_col = (pal_rd_idx < 17) ? m_pal[pal_rd_idx] : 0;
        if (!rst_n) begin
            rq = "R9";
            check(rq, "pen_idx", int'(pen_idx), m_pen);
            check(rq, "palette", int'(pal_rd_colour), exp_col);
            check(rq, "mode_pending", int'(mode_pending), m_pend);
            check(rq, "mode_active", int'(mode_active), m_act);
            check(rq, "lower_rom_en", int'(lower_rom_en), m_low);
            check(rq, "upper_rom_en", int'(upper_rom_en), m_up);
            check(rq, "irq_cnt_reset", int'(irq_cnt_reset), m_irq);
            check(rq, "bank_cfg", int'(bank_cfg), m_bank);
            check(rq, "bank_cfg_valid", int'(bank_cfg_valid), m_bval);
        end else begin
            check("R1/R2", "pen_idx", int'(pen_idx), m_pen);
            check("R3", "palette", int'(pal_rd_colour), exp_col);
            check("R4", "mode_pending", int'(mode_pending), m_pend);
            check("R5", "mode_active", int'(mode_active), m_act);
            check("R6", "lower_rom_en", int'(lower_rom_en), m_low);
            check("R6", "upper_rom_en", int'(upper_rom_en), m_up);
            check("R7", "irq_cnt_reset", int'(irq_cnt_reset), m_irq);
            check("R8", "bank_cfg", int'(bank_cfg), m_bank);
            check("R8", "bank_cfg_valid", int'(bank_cfg_valid), m_bval);
        end
    endtask

    // Model advances with the edge, then all outputs are compared 1 ns later
    always @(posedge clk) begin
        #1;
        if (!rst_n) model_reset();
        else        model_step();
        if (!finished) compare_all();
    end

    task automatic drive(input bit we, input logic [7:0] d, input bit ap, input bit ex);
        @(negedge clk);
        wr_en = we; wr_data = d; mode_apply = ap; ram_exp_en = ex;
        pal_rd_idx = pal_rd_idx + 5'd1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 8'hA5, 1'b0, 1'b0);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R2/R3: select every pen including border 16, give each a colour
        for (int p = 0; p < 17; p++) begin
            drive(1'b1, {3'b000, 5'(p)}, 1'b0, 1'b0);
            drive(1'b1, {3'b010, 5'((p * 7 + 3) % 32)}, 1'b0, 1'b0);
        end
        // R3: out-of-range pen, colour must land nowhere
        drive(1'b1, {3'b000, 5'd20}, 1'b0, 1'b0);
        drive(1'b1, {3'b010, 5'd31}, 1'b0, 1'b0);
        idle(34);
        // R4/R5: pending without apply, then apply, then coincident write+apply
        drive(1'b1, 8'b1000_0010, 1'b0, 1'b0);
        idle(2);
        drive(1'b0, 8'h00, 1'b1, 1'b0);
        drive(1'b1, 8'b1000_0001, 1'b1, 1'b0);
        drive(1'b0, 8'h00, 1'b1, 1'b0);
        // R6/R7: all ROM bit combinations, with and without irq bit
        for (int r = 0; r < 8; r++) begin
            drive(1'b1, {3'b100, 1'(r >> 2), 2'(r), 2'b11}, 1'b0, 1'b0);
            idle(1);
        end
        drive(1'b1, 8'b1001_0000, 1'b0, 1'b0);
        drive(1'b1, 8'b1001_0000, 1'b0, 1'b0);
        // R8: layout writes with expansion off then on
        drive(1'b1, 8'b1100_0101, 1'b0, 1'b0);
        idle(1);
        drive(1'b1, 8'b1100_0110, 1'b0, 1'b1);
        drive(1'b1, 8'b1100_0011, 1'b0, 1'b1);
        idle(2);
        // R1: mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            drive(1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
                  ($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)));
        end
        idle(2);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule